// File: doc/BRIEF.md
# Transmit Cell Buffer with Start-of-Cell Realignment

This block sits between a byte-wide cell source and a downstream cell processor on the transmit path. Bytes arrive one per clock with a valid qualifier and a start-of-cell strobe. The block stores up to four complete 53-byte cells and hands them to the reader one byte per read strobe. A cell becomes visible to the reader only when its final byte has been written.

The write side keeps track of cell boundaries. If the start strobe arrives while a cell is partly collected, the partial bytes are thrown away and the strobed byte begins a new cell. If a new cell begins while four cells are already stored, the whole incoming cell is dropped. Each of these two events sets a sticky status bit. The host clears both bits with a single read strobe, and one enable bit gates a level interrupt that covers both events. A flush control empties the buffer. While the flush control is held, every write is ignored.

Top module: `cell_tx_fifo`

## Requirements
- R1: The buffer holds at most four cells. `cell_avail` is 1 whenever at least one complete cell is stored and 0 otherwise, including right after reset.
- R2: Only complete cells are visible. A cell is committed on the clock edge that writes its 53rd byte, and `cell_avail` does not rise before that edge.
- R3: A byte written with `wr_soc`=1 at any position other than 0 discards the bytes already collected for the partial cell. That byte is stored as byte 0 of a new cell, and `stat_soc` is set.
- R4: `rd_data` presents the oldest stored byte, with cells and bytes in write order. `rd_soc` is 1 exactly on byte 0 of a cell. Each clock with `rd_en`=1 advances by one byte. `rd_en` has no effect while `cell_avail` is 0.
- R5: If byte 0 of a cell is written while four cells are stored, every byte of that cell is discarded, the stored cells are unchanged, and `stat_ovr` is set.
- R6: A clock with `stat_rd`=1 clears both `stat_soc` and `stat_ovr`. An event in the same clock sets its bit instead of clearing it.
- R7: `irq` is `int_en` AND (`stat_soc` OR `stat_ovr`), a level that follows those bits combinationally.
- R8: While `flush`=1 the buffer is emptied (`cell_avail` goes to 0 after one edge), and written bytes are ignored. After release, the next written byte is byte 0 of a new cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte qualifier |
| wr_soc | input | 1 | Start-of-cell strobe for the written byte |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Consume the presented byte |
| rd_data | output | 8 | Presented byte |
| rd_soc | output | 1 | Presented byte is byte 0 of a cell |
| cell_avail | output | 1 | At least one complete cell stored |
| flush | input | 1 | Soft reset control: empty the buffer and block writes |
| int_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status register read strobe (clears status) |
| stat_soc | output | 1 | Misplaced start-of-cell seen |
| stat_ovr | output | 1 | Cell dropped because the buffer was full |
| irq | output | 1 | Level interrupt |

## Verification
Cells are sent in three ways, and each one separates a different fault. The first is back-to-back cells drained while more are written, which checks byte order and commit timing. The second is a 10-byte fragment cut off by a new start strobe, which shows whether stale bytes or a wrong position leak into the stored cell. The third is a fifth cell offered to a full buffer, which shows whether any dropped byte overwrites stored data. A flush with writes held during it confirms that nothing leaks across the flush. The interrupt is checked with the enable both off and on, and the status bits are checked before and after the read strobe.

// File: rtl/cell_tx_fifo.sv
module cell_tx_fifo #(
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 4,
  parameter int W          = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic         wr_soc,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_soc,
  output logic         cell_avail,
  input  logic         flush,
  input  logic         int_en,
  input  logic         stat_rd,
  output logic         stat_soc,
  output logic         stat_ovr,
  output logic         irq
);
  localparam int BW = $clog2(CELL_BYTES);
  localparam int SW = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int CW = $clog2(CELLS + 1);
  localparam int AW = $clog2(CELLS * CELL_BYTES);

  logic [W-1:0]  mem [CELLS*CELL_BYTES];
  logic [BW-1:0] wbyte, rbyte, wpos;
  logic [SW-1:0] wslot, rslot;
  logic [CW-1:0] count;
  logic          drop;

  wire wr_ok     = wr_valid && !flush;
  wire first     = (wbyte == '0) || wr_soc;
  wire misplaced = wr_ok && wr_soc && (wbyte != '0);
  wire full      = (count == CW'(CELLS));
  wire keep      = first ? !full : !drop;
  wire ovr_evt   = wr_ok && first && full;
  wire commit    = wr_ok && keep && (wpos == BW'(CELL_BYTES-1));
  wire pop       = rd_en && cell_avail && !flush && (rbyte == BW'(CELL_BYTES-1));

  assign wpos       = first ? '0 : wbyte;
  assign cell_avail = (count != '0);
  assign rd_data    = mem[AW'(rslot) * AW'(CELL_BYTES) + AW'(rbyte)];
  assign rd_soc     = cell_avail && (rbyte == '0);
  assign irq        = int_en && (stat_soc || stat_ovr);

  always_ff @(posedge clk)
    if (wr_ok && keep) mem[AW'(wslot) * AW'(CELL_BYTES) + AW'(wpos)] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte <= '0; rbyte <= '0; wslot <= '0; rslot <= '0; count <= '0; drop <= 1'b0;
    end else if (flush) begin
      wbyte <= '0; rbyte <= '0; wslot <= '0; rslot <= '0; count <= '0; drop <= 1'b0;
    end else begin
      if (wr_valid) begin
        if (first) drop <= full;
        wbyte <= (wpos == BW'(CELL_BYTES-1)) ? '0 : wpos + 1'b1;
      end
      if (commit) wslot <= (wslot == SW'(CELLS-1)) ? '0 : wslot + 1'b1;
      if (rd_en && cell_avail) begin
        rbyte <= (rbyte == BW'(CELL_BYTES-1)) ? '0 : rbyte + 1'b1;
        if (pop) rslot <= (rslot == SW'(CELLS-1)) ? '0 : rslot + 1'b1;
      end
      count <= count + CW'(commit) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_soc <= 1'b0; stat_ovr <= 1'b0;
    end else begin
      stat_soc <= misplaced || (stat_soc && !stat_rd);
      stat_ovr <= ovr_evt   || (stat_ovr && !stat_rd);
    end
  end

  assert_count_le_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CELLS));
  assert_soc_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    misplaced |=> stat_soc);
  assert_ovr_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !rd_en) |=> (stat_ovr && count == CW'(CELLS)));
  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wr_valid) |=> (!stat_soc && !stat_ovr));
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cell_avail);
  assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);
endmodule

// File: tb/test_cell_tx_fifo.sv
module test_cell_tx_fifo;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_soc = 0, rd_en = 0, extra_rd = 0;
  logic [7:0] wr_data = 0;
  logic flush = 0, int_en = 0, stat_rd = 0;
  logic [7:0] rd_data;
  logic rd_soc, cell_avail, stat_soc, stat_ovr, irq;
  int checks = 0, errors = 0;
  logic [8:0] q [$];
  bit mon_on = 0;

  always #10 clk = ~clk;

  cell_tx_fifo i_cell_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_soc(wr_soc), .wr_data(wr_data),
    .rd_en(rd_en | extra_rd), .rd_data(rd_data), .rd_soc(rd_soc), .cell_avail(cell_avail),
    .flush(flush), .int_en(int_en), .stat_rd(stat_rd), .stat_soc(stat_soc),
    .stat_ovr(stat_ovr), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int n, input int seed, input bit soc, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_soc = soc && (i == 0); wr_data = 8'((seed * 7 + i * 3) & 255);
      if (push) q.push_back({i == 0, wr_data});
    end
    @(negedge clk);
    wr_valid = 0; wr_soc = 0;
  endtask

  // monitor: R4 order and start marker
  always @(negedge clk) begin
    rd_en = 0;
    if (mon_on && cell_avail) begin
      logic [8:0] e;
      if (q.size() == 0) chk(0, "R4 unexpected byte", rd_data, -1);
      else begin
        e = q.pop_front();
        chk({rd_soc, rd_data} == e, "R4 byte/soc", {rd_soc, rd_data}, e);
      end
      rd_en = 1;
    end
  end

  task automatic drain();
    mon_on = 1;
    for (int k = 0; k < 2000 && (q.size() != 0 || cell_avail); k++) @(negedge clk);
    mon_on = 0;
    @(negedge clk);
    chk(q.size() == 0, "R4 drained", q.size(), 0);
    chk(cell_avail == 0, "R1 empty after drain", cell_avail, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cell_avail == 0 && stat_soc == 0 && stat_ovr == 0 && irq == 0, "R1 reset state",
        {cell_avail, stat_soc, stat_ovr, irq}, 0);
    rst_n = 1;
    // R4: read strobe with nothing stored is ignored
    @(negedge clk); extra_rd = 1; repeat (3) @(negedge clk); extra_rd = 0;
    // R2: not visible before the last byte
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      chk(cell_avail == 0, "R2 not before commit", cell_avail, 0);
      wr_valid = 1; wr_soc = (i == 0); wr_data = 8'(100 + i);
      q.push_back({i == 0, wr_data});
    end
    @(negedge clk); wr_valid = 0; wr_soc = 0;
    chk(cell_avail == 1, "R2 visible after 53rd byte", cell_avail, 1);
    drain();
    // back-to-back cells with concurrent draining
    mon_on = 1;
    for (int c = 0; c < 6; c++) send(53, c + 1, 1, 1);
    drain();
    // R3: misplaced start-of-cell
    send(10, 40, 1, 0);
    send(53, 41, 1, 1);
    chk(stat_soc == 1, "R3 stat_soc set", stat_soc, 1);
    chk(irq == 0, "R7 irq gated off", irq, 0);
    int_en = 1; #1;
    chk(irq == 1, "R7 irq enabled", irq, 1);
    drain();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk(stat_soc == 0 && irq == 0, "R6 cleared by read", {stat_soc, irq}, 0);
    // R5: overrun
    for (int c = 0; c < 4; c++) send(53, 50 + c, 1, 1);
    chk(stat_ovr == 0, "R5 no overrun at four", stat_ovr, 0);
    send(53, 90, 1, 0);
    chk(stat_ovr == 1, "R5 stat_ovr set", stat_ovr, 1);
    chk(irq == 1, "R7 irq on overrun", irq, 1);
    drain();
    chk(stat_ovr == 1, "R6 sticky until read", stat_ovr, 1);
    // R6: event in the same clock as the read wins
    send(53, 60, 1, 1); send(5, 61, 1, 0);
    @(negedge clk); wr_valid = 1; wr_soc = 1; wr_data = 8'h77; stat_rd = 1;
    q.push_back({1'b1, 8'h77});
    @(negedge clk); stat_rd = 0;
    chk(stat_soc == 1 && stat_ovr == 0, "R6 set wins", {stat_soc, stat_ovr}, 2);
    for (int i = 1; i < 53; i++) begin
      wr_soc = 0; wr_data = 8'(i); q.push_back({1'b0, wr_data}); @(negedge clk);
    end
    wr_valid = 0;
    drain();
    // R8: flush
    send(53, 70, 1, 0); send(53, 71, 1, 0); send(20, 72, 1, 0);
    chk(cell_avail == 1, "R8 cells before flush", cell_avail, 1);
    @(negedge clk); flush = 1;
    @(negedge clk);
    chk(cell_avail == 0, "R8 emptied", cell_avail, 0);
    send(53, 73, 1, 0);
    chk(cell_avail == 0, "R8 writes ignored", cell_avail, 0);
    flush = 0;
    send(53, 74, 0, 1);
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule